// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block watches an SDRAM command bus without driving anything on it. Each cycle it decodes the chip-select, row-strobe, column-strobe and write-enable lines into a command. For every bank it keeps the open or closed state and a set of countdown timers. Some timers are global: mode-set recovery, refresh recovery and the activate-to-activate gap across banks. Any command that arrives too early, or that is illegal for the current bank state, raises an error. The error is a code plus the bank it concerns.

The minimum cycle counts for the activate-related rules are configuration inputs, so one instance can check a controller at several clock rates. The fixed rules are parameters: mode-set recovery, refresh recovery, write-data-to-precharge and the internal auto-precharge delay. The first violation is captured and held until the clear input is pulsed. This makes the block usable in simulation and as an on-chip sticky monitor.

Top module: `sdram_cmd_checker`

## Requirements
- R1: Commands decode from {cs_n, ras_n, cas_n, we_n}: 0000 mode set, 0011 activate, 0101 read, 0100 write, 0010 precharge (a10=1 covers every bank), 0001 auto refresh, 0110 burst stop. 0111, or cs_n high with any other lines, is a no-operation and never causes a violation.
- R2: A violation on the command in cycle k shows on err, err_code and err_bank after the edge ending cycle k. Later violations do not change the captured values. A cycle with clr high clears err and captures nothing, even if that cycle's command is itself a violation.
- R3: A read or write fewer than cfg_trcd cycles after an activate to the same bank gives code 3.
- R4: A precharge that reaches an open bank fewer than cfg_tras cycles after that bank's activate gives code 4.
- R5: An activate fewer than cfg_trc cycles after the previous activate to the same bank gives code 5.
- R6: An activate to a bank, or an auto refresh, fewer than cfg_trp cycles after that bank was closed by a precharge gives code 6.
- R7: An activate to a different bank than the previous activate, fewer than cfg_trrd cycles after it, gives code 7.
- R8: Any command other than a no-operation, burst stop included, fewer than T_MRD (default 2) cycles after a mode set gives code 1. The reported bank is the command's bank input.
- R9: Any command other than a no-operation fewer than T_RFC (default 9) cycles after an auto refresh gives code 2.
- R10: A precharge reaching a bank fewer than T_DPL (default 2) cycles after write data for that bank gives code 8. Write data belongs to the bank of the write in the same cycle, or else to the bank of the most recent write.
- R11: A read or write with a10=1 closes its bank at once. The bank's precharge window ends cfg_trp + AP_LAT (default 2) cycles after that command, and it is enforced as code 6.
- R12: An activate to an open bank gives code 9. A read or write to a closed bank gives code 10. An auto refresh while any bank is open gives code 11.
- R13: When one command breaks several rules, the lowest code is reported. The bank is the lowest-numbered bank that breaks the chosen rule.
- R14: After reset err is 0, err_code is 0 and err_bank is 0, all banks are closed and no timer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clears the captured error |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | NB_W (2) | Bank address |
| a10 | input | 1 | All-banks / auto-precharge flag |
| wdata_vld | input | 1 | Write data present on the bus this cycle |
| cfg_trcd | input | CNT_W (6) | Activate to read/write, cycles |
| cfg_tras | input | CNT_W (6) | Activate to precharge, cycles |
| cfg_trc | input | CNT_W (6) | Activate to activate, same bank, cycles |
| cfg_trp | input | CNT_W (6) | Precharge to activate or refresh, cycles |
| cfg_trrd | input | CNT_W (6) | Activate to activate, other bank, cycles |
| err | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first violation |
| err_bank | output | NB_W (2) | Bank of the first violation |

## Verification
The assertions check the following on every cycle. The error capture stays sticky and obeys the clear. Any rising error carries the code that the priority logic chose. Each activate opens its bank. Each precharge or auto-precharge closes the bank and starts its precharge window. Each mode set or refresh arms its recovery window. Only the bench's command sequences can show that each window ends on exactly the right cycle. They also show that bank selection under all-bank precharge and refresh is right, that the priority is right when rules overlap, and that write data is attributed to the correct bank.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  typedef enum logic [2:0] {
    C_NOP, C_MRS, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_BST
  } cmd_e;

  // Lower value = higher reporting priority
  typedef enum logic [3:0] {
    V_NONE      = 4'd0,
    V_MRD       = 4'd1,
    V_RFC       = 4'd2,
    V_RCD       = 4'd3,
    V_RAS       = 4'd4,
    V_RC        = 4'd5,
    V_RP        = 4'd6,
    V_RRD       = 4'd7,
    V_DPL       = 4'd8,
    V_ACT_OPEN  = 4'd9,
    V_RW_CLOSED = 4'd10,
    V_REF_OPEN  = 4'd11
  } viol_e;

  localparam int NUM_CODES = 12;

  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    if (cs_n) return C_NOP;
    case ({ras_n, cas_n, we_n})
      3'b000:  return C_MRS;
      3'b011:  return C_ACT;
      3'b101:  return C_RD;
      3'b100:  return C_WR;
      3'b010:  return C_PRE;
      3'b001:  return C_REF;
      3'b110:  return C_BST;
      default: return C_NOP;
    endcase
  endfunction

  // A rule of N cycles blocks the N-1 cycles following the command
  function automatic int span_load(input int cycles);
    return (cycles > 0) ? cycles - 1 : 0;
  endfunction

endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int CNT_W  = 6,
  parameter int AP_LAT = 2,
  parameter int T_DPL  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_trcd,
  input  logic [CNT_W-1:0] cfg_tras,
  input  logic [CNT_W-1:0] cfg_trc,
  input  logic [CNT_W-1:0] cfg_trp,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             ap_i,
  input  logic             wdat_i,
  output logic             open_o,
  output logic             rcd_busy_o,
  output logic             ras_busy_o,
  output logic             rc_busy_o,
  output logic             rp_busy_o,
  output logic             dpl_busy_o
);
  import sdram_chk_pkg::*;

  localparam int RW = CNT_W + 2;

  logic          open_q;
  logic [RW-1:0] rcd_rem, ras_rem, rc_rem, rp_rem, dpl_rem;

  function automatic logic [RW-1:0] tick(input logic [RW-1:0] r);
    return (r != '0) ? r - 1'b1 : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      rcd_rem <= '0;
      ras_rem <= '0;
      rc_rem  <= '0;
      rp_rem  <= '0;
      dpl_rem <= '0;
    end else begin
      rcd_rem <= act_i ? RW'(span_load(int'(cfg_trcd))) : tick(rcd_rem);
      ras_rem <= act_i ? RW'(span_load(int'(cfg_tras))) : tick(ras_rem);
      rc_rem  <= act_i ? RW'(span_load(int'(cfg_trc)))  : tick(rc_rem);
      if (ap_i)
        rp_rem <= RW'(span_load(int'(cfg_trp) + AP_LAT));
      else if (pre_i && open_q)
        rp_rem <= RW'(span_load(int'(cfg_trp)));
      else
        rp_rem <= tick(rp_rem);
      dpl_rem <= wdat_i ? RW'(span_load(T_DPL)) : tick(dpl_rem);
      if (act_i)              open_q <= 1'b1;
      else if (pre_i || ap_i) open_q <= 1'b0;
    end
  end

  assign open_o     = open_q;
  assign rcd_busy_o = (rcd_rem != '0);
  assign ras_busy_o = (ras_rem != '0);
  assign rc_busy_o  = (rc_rem  != '0);
  assign rp_busy_o  = (rp_rem  != '0);
  assign dpl_busy_o = (dpl_rem != '0);

  // R12: an activate leaves the bank open
  p_act_opens_r12: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> open_o);
  // R6: closing an open bank by precharge arms its precharge window
  p_close_arms_rp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && open_o && !act_i && !ap_i && cfg_trp > 1) |=> (!open_o && rp_busy_o));
  // R11: auto-precharge closes the bank and arms the longer window
  p_ap_closes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_i && (int'(cfg_trp) + AP_LAT > 1)) |=> (!open_o && rp_busy_o));
  // R10: write data arms the write-to-precharge window
  p_wdat_arms_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wdat_i && T_DPL > 1) |=> dpl_busy_o);

endmodule

// File: rtl/sdram_glob_timer.sv
module sdram_glob_timer
  import sdram_chk_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int NB_W  = 2,
  parameter int T_MRD = 2,
  parameter int T_RFC = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd_i,
  input  logic [NB_W-1:0]  ba_i,
  input  logic [CNT_W-1:0] cfg_trrd,
  output logic             mrd_busy_o,
  output logic             rfc_busy_o,
  output logic             rrd_busy_o,
  output logic [NB_W-1:0]  last_ba_o
);
  localparam int MW = $clog2(T_MRD + 1) + 1;
  localparam int FW = $clog2(T_RFC + 1) + 1;
  localparam int RW = CNT_W + 1;

  logic [MW-1:0]   mrd_rem;
  logic [FW-1:0]   rfc_rem;
  logic [RW-1:0]   rrd_rem;
  logic [NB_W-1:0] last_ba_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mrd_rem   <= '0;
      rfc_rem   <= '0;
      rrd_rem   <= '0;
      last_ba_q <= '0;
    end else begin
      if (cmd_i == C_MRS)     mrd_rem <= MW'(span_load(T_MRD));
      else if (mrd_rem != '0) mrd_rem <= mrd_rem - 1'b1;
      if (cmd_i == C_REF)     rfc_rem <= FW'(span_load(T_RFC));
      else if (rfc_rem != '0) rfc_rem <= rfc_rem - 1'b1;
      if (cmd_i == C_ACT) begin
        rrd_rem   <= RW'(span_load(int'(cfg_trrd)));
        last_ba_q <= ba_i;
      end else if (rrd_rem != '0) begin
        rrd_rem <= rrd_rem - 1'b1;
      end
    end
  end

  assign mrd_busy_o = (mrd_rem != '0);
  assign rfc_busy_o = (rfc_rem != '0);
  assign rrd_busy_o = (rrd_rem != '0);
  assign last_ba_o  = last_ba_q;

  // R8: a mode set opens its recovery window on the next cycle
  p_mrs_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == C_MRS && T_MRD > 1) |=> mrd_busy_o);
  // R9: an auto refresh opens its recovery window on the next cycle
  p_ref_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == C_REF && T_RFC > 1) |=> rfc_busy_o);

endmodule

// File: rtl/sdram_err_latch.sv
module sdram_err_latch #(
  parameter int NB_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            viol_i,
  input  logic [3:0]      code_i,
  input  logic [NB_W-1:0] bank_i,
  output logic            err_o,
  output logic [3:0]      code_o,
  output logic [NB_W-1:0] bank_o
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      err_o  <= 1'b0;
      code_o <= '0;
      bank_o <= '0;
    end else if (viol_i && !err_o) begin
      err_o  <= 1'b1;
      code_o <= code_i;
      bank_o <= bank_i;
    end
  end

  // R2: a captured error holds its code and bank until cleared
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !clr) |=> (err_o && $stable(code_o) && $stable(bank_o)));
  // R2: clear has priority over a new violation
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !err_o);

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 6,
  parameter int AP_LAT    = 2,
  parameter int T_DPL     = 2,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 9,
  parameter int NB_W      = $clog2(NUM_BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [NB_W-1:0]  ba,
  input  logic             a10,
  input  logic             wdata_vld,
  input  logic [CNT_W-1:0] cfg_trcd,
  input  logic [CNT_W-1:0] cfg_tras,
  input  logic [CNT_W-1:0] cfg_trc,
  input  logic [CNT_W-1:0] cfg_trp,
  input  logic [CNT_W-1:0] cfg_trrd,
  output logic             err,
  output logic [3:0]       err_code,
  output logic [NB_W-1:0]  err_bank
);
  cmd_e cmd;
  logic is_act, is_rd, is_wr, is_col, is_pre, is_ref, non_nop;
  assign cmd     = decode_cmd(cs_n, ras_n, cas_n, we_n);
  assign is_act  = (cmd == C_ACT);
  assign is_rd   = (cmd == C_RD);
  assign is_wr   = (cmd == C_WR);
  assign is_col  = is_rd || is_wr;
  assign is_pre  = (cmd == C_PRE);
  assign is_ref  = (cmd == C_REF);
  assign non_nop = (cmd != C_NOP);

  // Bank that receives write data: this cycle's write, else the last write
  logic [NB_W-1:0] wr_ba_q, wd_ba;
  assign wd_ba = is_wr ? ba : wr_ba_q;
  always_ff @(posedge clk) begin
    if (!rst_n)     wr_ba_q <= '0;
    else if (is_wr) wr_ba_q <= ba;
  end

  logic [NUM_BANKS-1:0] tgt, act_b, pre_b, ap_b, wd_b;
  logic [NUM_BANKS-1:0] open_v, rcd_v, ras_v, rc_v, rp_v, dpl_v;

  always_comb begin
    tgt     = '0;
    tgt[ba] = 1'b1;
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign act_b[i] = is_act && (ba == NB_W'(i));
    assign pre_b[i] = is_pre && (a10 || ba == NB_W'(i));
    assign ap_b[i]  = is_col && a10 && (ba == NB_W'(i));
    assign wd_b[i]  = wdata_vld && (wd_ba == NB_W'(i));

    sdram_bank_track #(.CNT_W(CNT_W), .AP_LAT(AP_LAT), .T_DPL(T_DPL)) u_trk (
      .clk(clk), .rst_n(rst_n),
      .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_trc(cfg_trc), .cfg_trp(cfg_trp),
      .act_i(act_b[i]), .pre_i(pre_b[i]), .ap_i(ap_b[i]), .wdat_i(wd_b[i]),
      .open_o(open_v[i]), .rcd_busy_o(rcd_v[i]), .ras_busy_o(ras_v[i]),
      .rc_busy_o(rc_v[i]), .rp_busy_o(rp_v[i]), .dpl_busy_o(dpl_v[i])
    );
  end

  logic            mrd_busy, rfc_busy, rrd_busy;
  logic [NB_W-1:0] last_ba;

  sdram_glob_timer #(.CNT_W(CNT_W), .NB_W(NB_W), .T_MRD(T_MRD), .T_RFC(T_RFC)) u_glob (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .ba_i(ba), .cfg_trrd(cfg_trrd),
    .mrd_busy_o(mrd_busy), .rfc_busy_o(rfc_busy), .rrd_busy_o(rrd_busy),
    .last_ba_o(last_ba)
  );

  // One offender mask per rule; code picks the rule, mask picks the bank
  logic [NUM_BANKS-1:0] vmask [NUM_CODES];
  always_comb begin
    for (int c = 0; c < NUM_CODES; c++) vmask[c] = '0;
    if (non_nop && mrd_busy) vmask[V_MRD] = tgt;
    if (non_nop && rfc_busy) vmask[V_RFC] = tgt;
    if (is_col) vmask[V_RCD] = tgt & rcd_v;
    if (is_pre) vmask[V_RAS] = pre_b & open_v & ras_v;
    if (is_act) vmask[V_RC]  = tgt & rc_v;
    if (is_act)      vmask[V_RP] = tgt & rp_v;
    else if (is_ref) vmask[V_RP] = rp_v;
    if (is_act && rrd_busy && ba != last_ba) vmask[V_RRD] = tgt;
    if (is_pre) vmask[V_DPL]       = pre_b & dpl_v;
    if (is_act) vmask[V_ACT_OPEN]  = tgt & open_v;
    if (is_col) vmask[V_RW_CLOSED] = tgt & ~open_v;
    if (is_ref) vmask[V_REF_OPEN]  = open_v;
  end

  logic [3:0]           viol_code;
  logic [NUM_BANKS-1:0] sel_mask;
  logic [NB_W-1:0]      viol_bank;
  logic                 viol;
  always_comb begin
    viol_code = '0;
    sel_mask  = '0;
    viol_bank = '0;
    for (int c = NUM_CODES - 1; c >= 1; c--) begin
      if (|vmask[c]) begin
        viol_code = 4'(c);
        sel_mask  = vmask[c];
      end
    end
    for (int b = NUM_BANKS - 1; b >= 0; b--)
      if (sel_mask[b]) viol_bank = NB_W'(b);
  end
  assign viol = (viol_code != '0);

  sdram_err_latch #(.NB_W(NB_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .viol_i(viol), .code_i(viol_code), .bank_i(viol_bank),
    .err_o(err), .code_o(err_code), .bank_o(err_bank)
  );

  // R2: a rising error carries the code chosen on the previous cycle
  p_first_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (err_code == $past(viol_code)));
  // R13: a held error always carries a defined code
  p_code_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (err_code != 4'd0 && int'(err_code) < NUM_CODES));
  // R12: refresh with no open bank never reports the open-bank code
  p_ref_closed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && open_v == '0) |-> (viol_code != V_REF_OPEN));

endmodule

// File: tb/sdram_cmd_checker_test.sv
module sdram_cmd_checker_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic       a10 = 1'b0;
  logic       wdata_vld = 1'b0;
  logic [5:0] cfg_trcd = 6'd3, cfg_tras = 6'd6, cfg_trc = 6'd9;
  logic [5:0] cfg_trp = 6'd3, cfg_trrd = 6'd2;
  logic       err;
  logic [3:0] err_code;
  logic [1:0] err_bank;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_cmd_checker uut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a10(a10), .wdata_vld(wdata_vld),
    .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_trc(cfg_trc),
    .cfg_trp(cfg_trp), .cfg_trrd(cfg_trrd),
    .err(err), .err_code(err_code), .err_bank(err_bank)
  );

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] MRS = 4'b0000, ACT = 4'b0011, RD  = 4'b0101, WR = 4'b0100;
  localparam logic [3:0] PRE = 4'b0010, REF = 4'b0001, BST = 4'b0110, NOP = 4'b0111;
  localparam logic [3:0] DES = 4'b1000;

  // {cmd, bank, {a10, wdata, clr, exp_err}, exp_code, exp_bank}
  localparam logic [15:0] VEC [42] = '{
    {NOP, 2'd0, 4'b0000, 4'd0,  2'd0},  // 0
    {ACT, 2'd0, 4'b0000, 4'd0,  2'd0},  // 1
    {RD,  2'd0, 4'b0001, 4'd3,  2'd0},  // 2  R3 read 1 cycle after activate
    {NOP, 2'd0, 4'b0010, 4'd0,  2'd0},  // 3
    {RD,  2'd0, 4'b0000, 4'd0,  2'd0},  // 4  R3 boundary, 3 cycles
    {PRE, 2'd0, 4'b0001, 4'd4,  2'd0},  // 5  R4
    {NOP, 2'd0, 4'b0010, 4'd0,  2'd0},  // 6
    {ACT, 2'd0, 4'b0001, 4'd5,  2'd0},  // 7  R5 and R6 together, R13 picks 5
    {NOP, 2'd0, 4'b0010, 4'd0,  2'd0},  // 8
    {ACT, 2'd1, 4'b0000, 4'd0,  2'd0},  // 9  R7 boundary
    {ACT, 2'd2, 4'b0001, 4'd7,  2'd2},  // 10 R7
    {NOP, 2'd0, 4'b0010, 4'd0,  2'd0},  // 11
    {NOP, 2'd0, 4'b0000, 4'd0,  2'd0},  // 12
    {NOP, 2'd0, 4'b0000, 4'd0,  2'd0},  // 13
    {NOP, 2'd0, 4'b0000, 4'd0,  2'd0},  // 14
    {WR,  2'd1, 4'b0100, 4'd0,  2'd0},  // 15
    {PRE, 2'd1, 4'b0001, 4'd8,  2'd1},  // 16 R10
    {NOP, 2'd0, 4'b0010, 4'd0,  2'd0},  // 17
    {RD,  2'd1, 4'b0001, 4'd10, 2'd1},  // 18 R12 closed bank
    {NOP, 2'd0, 4'b0010, 4'd0,  2'd0},  // 19
    {ACT, 2'd0, 4'b0001, 4'd9,  2'd0},  // 20 R12 open bank
    {NOP, 2'd0, 4'b0010, 4'd0,  2'd0},  // 21
    {REF, 2'd0, 4'b0001, 4'd11, 2'd0},  // 22 R12 refresh, banks 0 and 2 open
    {NOP, 2'd0, 4'b0010, 4'd0,  2'd0},  // 23
    {RD,  2'd0, 4'b0001, 4'd2,  2'd0},  // 24 R9
    {NOP, 2'd0, 4'b0010, 4'd0,  2'd0},  // 25
    {NOP, 2'd0, 4'b0000, 4'd0,  2'd0},  // 26
    {NOP, 2'd0, 4'b0000, 4'd0,  2'd0},  // 27
    {NOP, 2'd0, 4'b0000, 4'd0,  2'd0},  // 28
    {NOP, 2'd0, 4'b0000, 4'd0,  2'd0},  // 29
    {NOP, 2'd0, 4'b0000, 4'd0,  2'd0},  // 30
    {MRS, 2'd0, 4'b0000, 4'd0,  2'd0},  // 31 R9 boundary, 9 cycles
    {BST, 2'd3, 4'b0001, 4'd1,  2'd3},  // 32 R8
    {NOP, 2'd0, 4'b0010, 4'd0,  2'd0},  // 33
    {DES, 2'd0, 4'b0000, 4'd0,  2'd0},  // 34 R1 deselect
    {PRE, 2'd0, 4'b1000, 4'd0,  2'd0},  // 35 precharge all
    {ACT, 2'd3, 4'b0000, 4'd0,  2'd0},  // 36
    {NOP, 2'd0, 4'b0000, 4'd0,  2'd0},  // 37
    {NOP, 2'd0, 4'b0000, 4'd0,  2'd0},  // 38
    {WR,  2'd3, 4'b1100, 4'd0,  2'd0},  // 39 write with auto-precharge
    {REF, 2'd0, 4'b0001, 4'd6,  2'd3},  // 40 R11 / R6 refresh inside window
    {NOP, 2'd0, 4'b0010, 4'd0,  2'd0}   // 41
  };

  function automatic string req_of(input logic [3:0] code);
    case (code)
      4'd1:  return "R8";
      4'd2:  return "R9";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R10";
      4'd9, 4'd10, 4'd11: return "R12";
      default: return "R1";
    endcase
  endfunction

  task automatic step(input logic [3:0] c, input logic [1:0] b, input logic ap,
                      input logic w, input logic cl, input logic e_err,
                      input logic [3:0] e_code, input logic [1:0] e_bank,
                      input string tag);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b; a10 = ap; wdata_vld = w; clr = cl;
    @(posedge clk);
    #2;
    checks++;
    if (err !== e_err || (e_err && (err_code !== e_code || err_bank !== e_bank))) begin
      errors++;
      $display("FAIL %s: err=%0b code=%0d bank=%0d, expected err=%0b code=%0d bank=%0d",
               tag, err, err_code, err_bank, e_err, e_code, e_bank);
    end
  endtask

  task automatic check_reset(input string tag);
    checks++;
    if (err !== 1'b0 || err_code !== 4'd0 || err_bank !== 2'd0) begin
      errors++;
      $display("FAIL %s: err=%0b code=%0d bank=%0d, expected err=0 code=0 bank=0",
               tag, err, err_code, err_bank);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    check_reset("R14 reset state");

    for (int i = 0; i < 42; i++) begin
      step(VEC[i][15:12], VEC[i][11:10], VEC[i][9], VEC[i][8], VEC[i][7],
           VEC[i][6], VEC[i][5:2], VEC[i][1:0],
           VEC[i][6] ? req_of(VEC[i][5:2]) : "R1 / R13 no violation");
    end

    // Directed: auto-precharge window, capture hold, clear priority
    rst_n = 1'b0; cfg_trc = 6'd0;
    {cs_n, ras_n, cas_n, we_n} = NOP; clr = 1'b0; a10 = 1'b0; wdata_vld = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    check_reset("R14 reset clears capture");

    step(ACT, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, "R11 setup");
    step(NOP, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, "R11 setup");
    step(NOP, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, "R11 setup");
    step(WR,  2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 2'd0, "R11 write auto-precharge");
    for (int k = 0; k < 4; k++)
      step(NOP, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, "R11 wait");
    step(ACT, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, "R11 activate at trp+AP_LAT");
    step(RD,  2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 2'd0, "R3 after reopen");
    step(NOP, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 2'd0, "R2 clear");
    step(ACT, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, "R11 setup");
    step(NOP, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, "R11 setup");
    step(NOP, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, "R11 setup");
    step(RD,  2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, "R11 read auto-precharge");
    for (int k = 0; k < 3; k++)
      step(NOP, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, "R11 wait");
    step(ACT, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6, 2'd1, "R11 activate one cycle early");
    step(RD,  2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6, 2'd1, "R2 first violation held");
    step(RD,  2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 2'd0, "R2 clear beats new violation");
    step(NOP, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, "R2 nothing captured in clear cycle");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule